// File: doc/BRIEF.md
# Compare and Branch Unit

This block settles control flow for a small three-stage processor. A compare step subtracts a second operand from a first one and writes no register. It keeps three condition flags: zero, negative and carry. The flags are captured on a rising clock edge, so a branch in a later cycle can test them.

The second operand comes either from a register or from an immediate, chosen by a select input. A branch supplies a 3-bit condition code and an 11-bit signed offset. The unit compares the code against the stored flags. It raises a taken signal and presents the next program counter: the target `pc + offset` if the branch is taken, and `pc + 1` if it is not. Both sums wrap at the address width.

Top module: `cmp_branch_unit`

## Requirements
- R1: When `cmp_go` is high at a rising edge, the flags take the result of `op_a - operand2`. When `cmp_go` is low, the flags keep their value.
- R2: The zero flag is set exactly when the 16-bit difference is zero.
- R3: The negative flag equals bit 15 of the difference.
- R4: The carry flag is set when the subtraction does not borrow, that is when `op_a >= operand2` as unsigned numbers.
- R5: `imm_sel` = 1 makes `op_b_imm` the second operand. `imm_sel` = 0 makes `op_b_reg` the second operand.
- R6: The branch tests only the registered flags. Codes: 0 taken if zero=1, 1 taken if zero=0, 2 taken if negative=1, 3 taken if negative=0, 4 taken if carry=1, 5 always taken. A compare in the same cycle as the branch does not affect that branch.
- R7: When taken, `next_pc` = `pc` + the 11-bit `br_ofs` sign-extended to 16 bits, modulo 2^16.
- R8: When not taken, `next_pc` = `pc + 1` modulo 2^16, so 0xFFFF gives 0x0000.
- R9: With `rst` high at a rising edge, all three flags become 0 on that edge.
- R10: Codes 6 and 7 are never taken, whatever the flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmp_go | input | 1 | Compare strobe |
| imm_sel | input | 1 | 1: immediate is the second operand |
| op_a | input | 16 | First compare operand |
| op_b_reg | input | 16 | Register second operand |
| op_b_imm | input | 16 | Immediate second operand |
| br_cc | input | 3 | Branch condition code |
| br_ofs | input | 11 | Signed branch offset |
| pc | input | 16 | Current program counter |
| flag_z | output | 1 | Registered zero flag |
| flag_n | output | 1 | Registered negative flag |
| flag_c | output | 1 | Registered carry (no-borrow) flag |
| br_taken | output | 1 | Branch condition holds |
| next_pc | output | 16 | Next program counter |

## Verification
The bench builds the unit with its default 16-bit data width and 11-bit offset. At these sizes the extreme values are easy to drive:
- a 0x8000 difference for the sign flag;
- offsets of -1024 and +1023;
- a program counter of 0xFFFF, where both the fall-through sum and the target sum wrap.

Random operand pairs rarely match by chance, so equal pairs are forced often enough to exercise the zero flag and the equality boundary of the carry flag.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

    typedef enum logic [2:0] {
        CC_ZSET  = 3'd0,
        CC_ZCLR  = 3'd1,
        CC_NSET  = 3'd2,
        CC_NCLR  = 3'd3,
        CC_CSET  = 3'd4,
        CC_ALWAY = 3'd5,
        CC_NEVA  = 3'd6,
        CC_NEVB  = 3'd7
    } cc_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
    } flags_t;

    typedef struct packed {
        flags_t flags;
    } state_t;

endpackage

// File: rtl/cbu_compare.sv
module cbu_compare #(
    parameter int W = 16
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output cbu_pkg::flags_t res
);
    localparam logic [W:0] ONE = (W+1)'(1);

    logic [W:0]   sum;
    logic [W-1:0] diff;

    always_comb begin
        // a + ~b + 1: the carry out means no borrow
        sum   = {1'b0, a} + {1'b0, ~b} + ONE;
        diff  = sum[W-1:0];
        res.z = (diff == '0);
        res.n = diff[W-1];
        res.c = sum[W];
    end
endmodule

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval (
    input  logic [2:0]      cc,
    input  cbu_pkg::flags_t fl,
    output logic            taken
);
    import cbu_pkg::*;

    always_comb begin
        unique case (cc_e'(cc))
            CC_ZSET:  taken = fl.z;
            CC_ZCLR:  taken = ~fl.z;
            CC_NSET:  taken = fl.n;
            CC_NCLR:  taken = ~fl.n;
            CC_CSET:  taken = fl.c;
            CC_ALWAY: taken = 1'b1;
            default:  taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/cbu_pc_next.sv
module cbu_pc_next #(
    parameter int W     = 16,
    parameter int OFS_W = 11
) (
    input  logic [W-1:0]     pc,
    input  logic [OFS_W-1:0] ofs,
    input  logic             take,
    output logic [W-1:0]     npc
);
    logic [W-1:0] ofs_ext;

    generate
        if (OFS_W < W) begin : g_sext
            localparam int EXT = W - OFS_W;
            assign ofs_ext = {{EXT{ofs[OFS_W-1]}}, ofs};
        end else begin : g_trunc
            assign ofs_ext = ofs[W-1:0];
        end
    endgenerate

    always_comb begin
        npc = take ? (pc + ofs_ext) : (pc + W'(1));
    end
endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit #(
    parameter int DATA_W = 16,
    parameter int OFS_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_go,
    input  logic              imm_sel,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b_reg,
    input  logic [DATA_W-1:0] op_b_imm,
    input  logic [2:0]        br_cc,
    input  logic [OFS_W-1:0]  br_ofs,
    input  logic [DATA_W-1:0] pc,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_c,
    output logic              br_taken,
    output logic [DATA_W-1:0] next_pc
);
    import cbu_pkg::*;

    state_t            st_d, st_q;
    flags_t            cmp_res;
    logic [DATA_W-1:0] operand2;
    logic              take;

    assign operand2 = imm_sel ? op_b_imm : op_b_reg;

    cbu_compare #(.W(DATA_W)) u_cmp (
        .a   (op_a),
        .b   (operand2),
        .res (cmp_res)
    );

    cbu_cond_eval u_cond (
        .cc    (br_cc),
        .fl    (st_q.flags),
        .taken (take)
    );

    cbu_pc_next #(.W(DATA_W), .OFS_W(OFS_W)) u_pc (
        .pc   (pc),
        .ofs  (br_ofs),
        .take (take),
        .npc  (next_pc)
    );

    always_comb begin
        st_d = st_q;
        if (cmp_go) begin
            st_d.flags = cmp_res;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_z   = st_q.flags.z;
    assign flag_n   = st_q.flags.n;
    assign flag_c   = st_q.flags.c;
    assign br_taken = take;
endmodule

// File: rtl/cbu_checker.sv
module cbu_checker #(
    parameter int DATA_W = 16,
    parameter int OFS_W  = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              cmp_go,
    input logic              imm_sel,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b_reg,
    input logic [DATA_W-1:0] op_b_imm,
    input logic [2:0]        br_cc,
    input logic [OFS_W-1:0]  br_ofs,
    input logic [DATA_W-1:0] pc,
    input logic              flag_z,
    input logic              flag_n,
    input logic              flag_c,
    input logic              br_taken,
    input logic [DATA_W-1:0] next_pc
);
    logic [DATA_W-1:0] sel_b;
    logic [DATA_W-1:0] diff;
    logic [DATA_W-1:0] ofs_wide;

    assign sel_b    = imm_sel ? op_b_imm : op_b_reg;
    assign diff     = op_a - sel_b;
    assign ofs_wide = DATA_W'($signed(br_ofs));

    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        !cmp_go |=> $stable({flag_z, flag_n, flag_c}));

    a_r2_zero: assert property (@(posedge clk) disable iff (rst)
        cmp_go |=> flag_z == ($past(op_a) == $past(sel_b)));

    a_r3_sign: assert property (@(posedge clk) disable iff (rst)
        cmp_go |=> flag_n == $past(diff[DATA_W-1]));

    a_r4_carry: assert property (@(posedge clk) disable iff (rst)
        cmp_go |=> flag_c == ($past(op_a) >= $past(sel_b)));

    a_r6_always: assert property (@(posedge clk) disable iff (rst)
        br_cc == 3'd5 |-> br_taken);

    a_r7_target: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> next_pc == DATA_W'(pc + ofs_wide));

    a_r8_fallthru: assert property (@(posedge clk) disable iff (rst)
        !br_taken |-> next_pc == DATA_W'(pc + 1'b1));

    a_r9_reset: assert property (@(posedge clk)
        rst |=> !flag_z && !flag_n && !flag_c);

    a_r10_never: assert property (@(posedge clk) disable iff (rst)
        br_cc[2:1] == 2'b11 |-> !br_taken);
endmodule

bind cmp_branch_unit cbu_checker #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmp_go   (cmp_go),
    .imm_sel  (imm_sel),
    .op_a     (op_a),
    .op_b_reg (op_b_reg),
    .op_b_imm (op_b_imm),
    .br_cc    (br_cc),
    .br_ofs   (br_ofs),
    .pc       (pc),
    .flag_z   (flag_z),
    .flag_n   (flag_n),
    .flag_c   (flag_c),
    .br_taken (br_taken),
    .next_pc  (next_pc)
);

// File: tb/cmp_branch_unit_bench.sv
module cmp_branch_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmp_go, imm_sel;
    logic [15:0] op_a, op_b_reg, op_b_imm, pc;
    logic [2:0]  br_cc;
    logic [10:0] br_ofs;
    logic        flag_z, flag_n, flag_c, br_taken;
    logic [15:0] next_pc;

    int checks = 0;
    int errors = 0;
    logic mz, mn, mc;

    always #10 clk = ~clk;

    cmp_branch_unit u_cmp_branch_unit (
        .clk(clk), .rst(rst), .cmp_go(cmp_go), .imm_sel(imm_sel),
        .op_a(op_a), .op_b_reg(op_b_reg), .op_b_imm(op_b_imm),
        .br_cc(br_cc), .br_ofs(br_ofs), .pc(pc),
        .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c),
        .br_taken(br_taken), .next_pc(next_pc)
    );

    function automatic logic [2:0] exp_flags(input logic [15:0] a, input logic [15:0] b);
        logic [15:0] d;
        d = a - b;
        return {d == 16'd0, d[15], a >= b};
    endfunction

    function automatic logic exp_taken(input logic [2:0] cc, input logic z, input logic n, input logic c);
        case (cc)
            3'd0: return z;
            3'd1: return !z;
            3'd2: return n;
            3'd3: return !n;
            3'd4: return c;
            3'd5: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] exp_next(input logic [15:0] p, input logic [10:0] o, input logic t);
        return t ? p + {{5{o[10]}}, o} : p + 16'd1;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic step(input logic cmp, input logic imm, input logic [15:0] a,
                        input logic [15:0] br, input logic [15:0] bi, input logic [2:0] cc,
                        input logic [10:0] o, input logic [15:0] p, input string ftag);
        logic t;
        logic [2:0] ef;
        cmp_go = cmp; imm_sel = imm; op_a = a; op_b_reg = br; op_b_imm = bi;
        br_cc = cc; br_ofs = o; pc = p;
        #1;
        t = exp_taken(cc, mz, mn, mc);
        chk(br_taken == t, (cc >= 3'd6) ? "R10" : "R6", 16'(br_taken), 16'(t));
        chk(next_pc == exp_next(p, o, t), t ? "R7" : "R8", next_pc, exp_next(p, o, t));
        @(posedge clk);
        if (cmp) begin
            ef = exp_flags(a, imm ? bi : br);
            {mz, mn, mc} = ef;
        end
        #1;
        chk({flag_z, flag_n, flag_c} == {mz, mn, mc}, ftag,
            16'({flag_z, flag_n, flag_c}), 16'({mz, mn, mc}));
    endtask

    task automatic do_reset;
        rst = 1'b1;
        @(posedge clk);
        #1;
        {mz, mn, mc} = 3'b000;
        chk({flag_z, flag_n, flag_c} == 3'b000, "R9", 16'({flag_z, flag_n, flag_c}), 16'd0);
        rst = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd5813));
        rst = 1'b1; cmp_go = 0; imm_sel = 0; op_a = 0; op_b_reg = 0; op_b_imm = 0;
        br_cc = 3'd7; br_ofs = 0; pc = 0;
        {mz, mn, mc} = 3'b000;
        @(negedge clk);
        do_reset();

        // R2 R4: equal operands give zero and carry
        step(1, 0, 16'h1234, 16'h1234, 16'h0000, 3'd7, 11'd0, 16'h0010, "R2");
        step(0, 0, 16'h0, 16'h0, 16'h0, 3'd0, 11'd5, 16'h0010, "R1");   // R6 EQ taken
        // R3 R4: 0 - 1 borrows, negative
        step(1, 0, 16'h0000, 16'h0001, 16'h0, 3'd7, 11'd0, 16'h0020, "R3");
        step(0, 0, 16'h0, 16'h0, 16'h0, 3'd4, 11'd3, 16'h0020, "R4");    // CS not taken
        step(0, 0, 16'h0, 16'h0, 16'h0, 3'd2, 11'h400, 16'h0000, "R1");  // R7 -1024 wraps
        // R5: immediate selected, register value ignored
        step(1, 1, 16'h0005, 16'h0005, 16'h0003, 3'd7, 11'd0, 16'h0030, "R5");
        step(0, 0, 16'h0, 16'h0, 16'h0, 3'd1, 11'h3FF, 16'hFF00, "R5");  // NE taken, +1023 wraps
        // R3: 0x8000 difference sign
        step(1, 0, 16'h8000, 16'h0000, 16'h0, 3'd7, 11'd0, 16'h0040, "R3");
        step(0, 0, 16'h0, 16'h0, 16'h0, 3'd3, 11'd1, 16'hFFFF, "R1");    // R8 wrap to 0
        // R6: same-cycle compare not visible to branch
        step(1, 0, 16'h0007, 16'h0007, 16'h0, 3'd0, 11'd9, 16'h0050, "R1");
        // R10: never codes with flags set
        step(0, 0, 16'h0, 16'h0, 16'h0, 3'd6, 11'd9, 16'h0060, "R1");
        step(0, 0, 16'h0, 16'h0, 16'h0, 3'd7, 11'd9, 16'h0060, "R1");
        step(0, 0, 16'h0, 16'h0, 16'h0, 3'd5, 11'd9, 16'h0060, "R1");
        do_reset();

        for (int i = 0; i < 3000; i++) begin
            logic [15:0] ra, rb, ri;
            ra = 16'($urandom);
            rb = ($urandom % 4 == 0) ? ra : 16'($urandom);
            ri = ($urandom % 4 == 0) ? ra : 16'($urandom);
            step(1'($urandom), 1'($urandom), ra, rb, ri, 3'($urandom),
                 11'($urandom), 16'($urandom), "R1");
            if (i == 1500) do_reset();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule